// File: doc/BRIEF.md
# Serial/Parallel Latched Switch Word Controller

This block drives six complementary gate-control pairs, for example for an RF switch, a step attenuator or a phase shifter. One staging register holds the next control word. A mode pin picks how that register is filled. In serial mode it is filled by a three-wire shift interface (data, shift clock, latch strobe), most significant bit first. In parallel mode it follows six parallel pins continuously, without waiting for any clock edge.

A latch strobe copies the staging register into the output latch. Each latched bit leaves the block as a true output and an inverted output. While the strobe is high, the serial shift clock is masked, so the staged word cannot move while it is being loaded. While the strobe is low, the outputs hold, whatever the other pins do.

All pins are asynchronous to the system clock and pass through a two-flop synchronizer. The shift clock is then edge-detected in the system clock domain. This assumes the shift clock stays high and low for at least two system clocks each. A reset-word input gives the power-up state: an active-low reset loads it into both the staging register and the output latch. All pins are plain levels. There is no valid/ready handshake and no back-pressure: the word moves only on the strobe, and a word that is overwritten before it is latched is simply lost.

Top module: `rfsw_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first latch, `drv_p` equals `rst_word` and `drv_n` equals its bitwise inverse.
- R2: `drv_n` is always the bitwise inverse of `drv_p`.
- R3: With `mode_ser` high and `ser_le` low, each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of the staging register, moving the older bits toward bit 5. After six edges, the first bit sent sits in bit 5 (MSB first).
- R4: If more than six bits are shifted before a latch, the staging register keeps only the last six bits sent.
- R5: While `ser_le` is high, rising edges of `ser_clk` do not shift the staging register.
- R6: While `ser_le` is low, `drv_p` and `drv_n` keep their value in every mode.
- R7: With `mode_ser` low and `ser_le` held high, `drv_p` follows `par_in` within four system clocks of a change (direct parallel operation).
- R8: With `mode_ser` low, a word set on `par_in` while `ser_le` is low reaches `drv_p` only after a high pulse on `ser_le` (latched parallel operation).
- R9: With `mode_ser` low, activity on `ser_clk` and `ser_dat` does not alter the staging register. It keeps following `par_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads `rst_word` |
| rst_word | input | 6 | Power-up control word |
| mode_ser | input | 1 | 1 = serial fill, 0 = parallel fill |
| ser_clk | input | 1 | Serial shift clock, rising-edge active |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; high loads the outputs and masks `ser_clk` |
| par_in | input | 6 | Parallel word input |
| drv_p | output | 6 | True control outputs |
| drv_n | output | 6 | Inverted control outputs |

## Verification
The bench targets these corner cases:
- **Bit order.** It sends an asymmetric serial word. A design that shifted LSB first, or shifted toward bit 0, would latch a mirrored word.
- **Overflow.** It sends nine bits before a latch. A design that saturated at six bits, or kept the first six, would show the leading junk bits.
- **Clock masking.** It toggles the shift clock while the strobe is high and then re-latches. A design without the mask would latch a shifted word.
- **Output hold and parallel mode.** It checks that outputs hold while parallel pins change with the strobe low. It also checks that serial traffic in parallel mode leaves the word intact. A transparent output stage, or a shifter that stays enabled in parallel mode, would each corrupt the driven word.

// File: rtl/rfsw_pkg.sv
package rfsw_pkg;
  localparam int unsigned CTL_W_DEF  = 6;
  localparam int unsigned SYNC_N_DEF = 2;

  typedef enum logic {
    FILL_PAR = 1'b0,
    FILL_SER = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/rfsw_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
module rfsw_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/rfsw_inreg.sv
// Staging register: MSB-first shifter or transparent parallel follower.
module rfsw_inreg
  import rfsw_pkg::*;
#(
  parameter int unsigned W = CTL_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_word,
  input  fill_mode_e   mode,
  input  logic         le_s,
  input  logic         sclk_s,
  input  logic         sdat_s,
  input  logic [W-1:0] par_s,
  output logic [W-1:0] word_q
);
  logic sclk_d;
  logic shift_ok;

  assign shift_ok = sclk_s & ~sclk_d & ~le_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= rst_word;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (mode == FILL_PAR) begin
        word_q <= par_s;
      end else if (shift_ok) begin
        word_q <= {word_q[W-2:0], sdat_s};
      end
    end
  end
endmodule

// File: rtl/rfsw_outlatch.sv
// Output latch with separately registered true and inverted drives.
module rfsw_outlatch #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_word,
  input  logic         le_s,
  input  logic [W-1:0] word,
  output logic [W-1:0] drv_p,
  output logic [W-1:0] drv_n
);
  for (genvar b = 0; b < W; b++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        drv_p[b] <= rst_word[b];
        drv_n[b] <= ~rst_word[b];
      end else if (le_s) begin
        drv_p[b] <= word[b];
        drv_n[b] <= ~word[b];
      end
    end
  end
endmodule

// File: rtl/rfsw_ctrl.sv
module rfsw_ctrl
  import rfsw_pkg::*;
#(
  parameter int unsigned CTL_W  = CTL_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] rst_word,
  input  logic             mode_ser,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  input  logic [CTL_W-1:0] par_in,
  output logic [CTL_W-1:0] drv_p,
  output logic [CTL_W-1:0] drv_n
);
  localparam int unsigned BUS_W = CTL_W + 4;

  logic [BUS_W-1:0] pins_a;
  logic [BUS_W-1:0] pins_s;
  logic             mode_s;
  logic             le_s;
  logic             sclk_s;
  logic             sdat_s;
  logic [CTL_W-1:0] par_s;
  logic [CTL_W-1:0] word_q;
  fill_mode_e       mode_e;

  assign pins_a = {mode_ser, ser_le, ser_clk, ser_dat, par_in};

  rfsw_sync #(.W(BUS_W), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_a),
    .q_sync  (pins_s)
  );

  assign {mode_s, le_s, sclk_s, sdat_s, par_s} = pins_s;
  assign mode_e = mode_s ? FILL_SER : FILL_PAR;

  rfsw_inreg #(.W(CTL_W)) u_inreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_word (rst_word),
    .mode     (mode_e),
    .le_s     (le_s),
    .sclk_s   (sclk_s),
    .sdat_s   (sdat_s),
    .par_s    (par_s),
    .word_q   (word_q)
  );

  rfsw_outlatch #(.W(CTL_W)) u_outl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_word (rst_word),
    .le_s     (le_s),
    .word     (word_q),
    .drv_p    (drv_p),
    .drv_n    (drv_n)
  );
endmodule

// File: rtl/rfsw_ctrl_chk.sv
module rfsw_ctrl_chk #(
  parameter int unsigned CTL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_s,
  input logic             le_s,
  input logic             sclk_s,
  input logic             sdat_s,
  input logic [CTL_W-1:0] par_s,
  input logic [CTL_W-1:0] word_q,
  input logic [CTL_W-1:0] drv_p,
  input logic [CTL_W-1:0] drv_n
);
  logic live;
  logic sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live      <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      live      <= 1'b1;
      sclk_prev <= sclk_s;
    end
  end

  // R2
  a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
    drv_n == ~drv_p);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !le_s) |=> $stable(drv_p));

  // R5
  a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_s && le_s) |=> $stable(word_q));

  // R3
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_s && !le_s && sclk_s && !sclk_prev) |=>
      word_q == {$past(word_q[CTL_W-2:0]), $past(sdat_s)});

  // R9
  a_r9_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !mode_s) |=> word_q == $past(par_s));

  // R7
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (live && le_s) |=> drv_p == $past(word_q));
endmodule

bind rfsw_ctrl rfsw_ctrl_chk #(.CTL_W(CTL_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_s (mode_s),
  .le_s   (le_s),
  .sclk_s (sclk_s),
  .sdat_s (sdat_s),
  .par_s  (par_s),
  .word_q (word_q),
  .drv_p  (drv_p),
  .drv_n  (drv_n)
);

// File: tb/rfsw_ctrl_bench.sv
`timescale 1ns/1ps
module rfsw_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rst_word = 6'b101101;
  logic       mode_ser = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_le = 1'b0;
  logic [5:0] par_in = 6'b000000;
  logic [5:0] drv_p;
  logic [5:0] drv_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rfsw_ctrl u_rfsw_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_word(rst_word), .mode_ser(mode_ser),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le), .par_in(par_in),
    .drv_p(drv_p), .drv_n(drv_n)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req, input logic [5:0] exp);
    check(req, drv_p, exp);
    check({req, "/R2"}, drv_n, ~exp);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_cyc(3);
    ser_clk = 1'b1;
    wait_cyc(3);
    ser_clk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic send_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le;
    ser_le = 1'b1;
    wait_cyc(4);
    ser_le = 1'b0;
    wait_cyc(5);
  endtask

  task automatic t_reset(input logic [5:0] w);
    rst_word = w;
    rst_n = 1'b0;
    wait_cyc(3);
    check_pair("R1 in reset", w);
    rst_n = 1'b1;
    wait_cyc(6);
    check_pair("R1 after reset", w);
  endtask

  task automatic t_serial;
    mode_ser = 1'b1;
    wait_cyc(4);
    send_word(6'b110010);
    check_pair("R6 serial before latch", rst_word);
    pulse_le();
    check_pair("R3 serial msb first", 6'b110010);
  endtask

  task automatic t_overflow;
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
    send_word(6'b011011);
    pulse_le();
    check_pair("R4 last six bits", 6'b011011);
  endtask

  task automatic t_mask;
    ser_le = 1'b1;
    wait_cyc(4);
    send_bit(1'b1);
    send_bit(1'b0);
    check_pair("R5 strobe high during clocks", 6'b011011);
    ser_le = 1'b0;
    wait_cyc(5);
    pulse_le();
    check_pair("R5 no shift under strobe", 6'b011011);
  endtask

  task automatic t_direct;
    mode_ser = 1'b0;
    par_in = 6'b000111;
    ser_le = 1'b1;
    wait_cyc(5);
    check_pair("R7 direct word a", 6'b000111);
    par_in = 6'b111000;
    wait_cyc(4);
    check_pair("R7 direct word b", 6'b111000);
    ser_le = 1'b0;
    wait_cyc(5);
  endtask

  task automatic t_latched;
    par_in = 6'b010101;
    wait_cyc(8);
    check_pair("R8/R6 hold before pulse", 6'b111000);
    pulse_le();
    check_pair("R8 latched after pulse", 6'b010101);
  endtask

  task automatic t_par_ignore;
    par_in = 6'b100110;
    wait_cyc(4);
    pulse_le();
    check_pair("R9 parallel loaded", 6'b100110);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    pulse_le();
    check_pair("R9 serial ignored", 6'b100110);
  endtask

  initial begin
    wait_cyc(2);
    t_reset(6'b101101);
    t_serial();
    t_overflow();
    t_mask();
    t_direct();
    t_latched();
    t_par_ignore();
    mode_ser = 1'b1;
    t_reset(6'b010010);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule